// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a compact Harvard-style processor core. Data values and addresses are W bits wide. It completes one 16-bit instruction in every clock, so fetch, decode and execute all happen in the same cycle. It has two memory ports. The instruction port puts out a fetch address and takes in a 16-bit word. The data port puts out an address, write data, a write strobe and a read strobe, and takes in read data. Both memories are synchronous and answer one clock after the address is presented. The core therefore drives the fetch address for the next instruction from combinational logic, and that instruction arrives just as the next cycle begins.

Every instruction carries four nibbles, from the top down: opcode, destination, source A and source B. The two source fields and the destination field select from one shared 16-entry operand space. That space holds the constants 0 and 1, the data-read port, the immediate, the data address register, the jump register, the successor fetch address and the general registers. Loads and stores always use the data address register as their memory address. Branches always go to the jump register. A halt instruction stops the core for good until the next reset, and a status output reports that the core has stopped.

Top module: `tcpu_core`

## Requirements
- R1: Bits [15:12] of an instruction are the opcode, [11:8] the destination rd, [7:4] source A, [3:0] source B. Opcode 1 writes A+B to rd and opcode 2 writes A−B to rd, both modulo 2**W.
- R2: Opcode 3 writes the low W bits of A×B to rd. Opcode 4 writes A shifted right by one to rd, filling the top bit with zero.
- R3: Opcode 8 writes the zero-extended 8-bit value {source-B field, source-A field} to rd. The source-B nibble is the upper half.
- R4: Operand codes are 0 = constant 0, 1 = constant 1, 2 = data read value, 3 = the {B,A} immediate of the current instruction, 4 = data address register, 5 = jump register, 6 = fetch address + 1, and 7 and up = general registers 1..NUM_GPR. Opcode 7 copies source A to rd. Writes to codes 0–3, 6 and codes beyond the last general register are ignored, and reads of those unused codes give 0.
- R5: Opcode 6 asserts the data write strobe for that one cycle, with the data address register as the address and the source-A value as the write data.
- R6: Opcode 5 asserts the data read strobe with the data address register as the address. The read value is available on operand code 2 from the next instruction onward and holds until the next load.
- R7: Opcode 9 fetches next from the jump register when A equals B. Otherwise it fetches from the current address + 1.
- R8: Opcode 10 fetches next from the jump register when A < B, compared as unsigned. Otherwise it fetches from the current address + 1.
- R9: Opcode 11 raises `halted` at the next clock. After that the fetch address stays fixed, no data strobe rises and no register changes, until reset.
- R10: While `rst` is high (synchronous, active high), the fetch address is 0, and after the first clock edge `halted` is low. The first instruction executed after reset is the one at address 0.
- R11: Opcode 0 and opcodes 12–15 change no register and no memory, and fetching continues with the next address.
- R12: Each non-branch instruction takes exactly one clock. A program of N straight-line instructions that ends with opcode 11 shows `halted` N clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | W | Instruction fetch address, registered by the instruction memory |
| imem_data | input | 16 | Instruction word, one clock after its address |
| dmem_addr | output | W | Data memory address (data address register) |
| dmem_wdata | output | W | Data memory write value |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_rdata | input | W | Data memory read value, one clock after a read strobe |
| halted | output | 1 | Core has executed the halt opcode |

## Verification
Because the fetch address is combinational, the program-counter update and a register or memory write land in the same cycle. The hardest case is a loop, where a taken branch follows an update of the very register it compares. A store-then-load to one address, and a load directly followed by a use of the read operand, test the same coupling on the data port. These cases are judged only by the final memory contents and by the exact number of cycles until `halted`, both worked out by hand from the requirements. The halt cycle also gets its own test: instructions placed after the halt must leave memory untouched and the fetch address unchanged.

// File: rtl/tcpu_core.sv
module tcpu_core #(
  parameter int W       = 8,
  parameter int NUM_GPR = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] imem_addr,
  input  logic [15:0]  imem_data,
  output logic [W-1:0] dmem_addr,
  output logic [W-1:0] dmem_wdata,
  output logic         dmem_we,
  output logic         dmem_re,
  input  logic [W-1:0] dmem_rdata,
  output logic         halted
);
  localparam int GPR_BASE = 7;
  localparam logic [3:0] OP_ADD = 4'd1, OP_SUB = 4'd2, OP_MUL = 4'd3, OP_DV2 = 4'd4,
                         OP_LDM = 4'd5, OP_STM = 4'd6, OP_MVR = 4'd7, OP_MVI = 4'd8,
                         OP_BEQ = 4'd9, OP_BLT = 4'd10, OP_END = 4'd11;
  localparam logic [3:0] SEL_AR = 4'd4, SEL_JR = 4'd5;

  logic [3:0]   op, rd, sa, sb;
  logic [W-1:0] pc, ar, jr, pc_inc, pc_nxt, va, vb, res;
  logic [W-1:0] gpr  [NUM_GPR];
  logic [W-1:0] srcs [16];
  logic         halt_q, wr, wr_en, take;

  assign {op, rd, sa, sb} = imem_data;
  assign pc_inc = pc + W'(1);

  always_comb begin
    for (int i = 0; i < 16; i++) srcs[i] = '0;
    srcs[1] = W'(1);
    srcs[2] = dmem_rdata;
    srcs[3] = W'({sb, sa});
    srcs[4] = ar;
    srcs[5] = jr;
    srcs[6] = pc_inc;
    for (int g = 0; g < NUM_GPR; g++) srcs[GPR_BASE+g] = gpr[g];
  end

  assign va = srcs[sa];
  assign vb = srcs[sb];

  always_comb begin
    res = '0;
    wr  = 1'b1;
    case (op)
      OP_ADD:  res = va + vb;
      OP_SUB:  res = va - vb;
      OP_MUL:  res = va * vb;
      OP_DV2:  res = va >> 1;
      OP_MVR:  res = va;
      OP_MVI:  res = W'({sb, sa});
      default: wr  = 1'b0;
    endcase
  end

  assign wr_en = wr && !halt_q;
  assign take  = !halt_q && ((op == OP_BEQ && va == vb) || (op == OP_BLT && va < vb));

  always_comb begin
    if (halt_q || op == OP_END) pc_nxt = pc;
    else if (take)              pc_nxt = jr;
    else                        pc_nxt = pc_inc;
  end

  assign imem_addr  = rst ? '0 : pc_nxt;
  assign dmem_addr  = ar;
  assign dmem_wdata = va;
  assign dmem_we    = !rst && !halt_q && op == OP_STM;
  assign dmem_re    = !rst && !halt_q && op == OP_LDM;
  assign halted     = halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      ar     <= '0;
      jr     <= '0;
      halt_q <= 1'b0;
      for (int g = 0; g < NUM_GPR; g++) gpr[g] <= '0;
    end else begin
      pc <= pc_nxt;
      if (!halt_q && op == OP_END) halt_q <= 1'b1;
      if (wr_en && rd == SEL_AR) ar <= res;
      if (wr_en && rd == SEL_JR) jr <= res;
      for (int g = 0; g < NUM_GPR; g++)
        if (wr_en && rd == 4'(GPR_BASE + g)) gpr[g] <= res;
    end
  end
endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] imem_addr,
  input logic [15:0]  imem_data,
  input logic         dmem_we,
  input logic         dmem_re,
  input logic         halted
);
  logic [3:0] opc;
  logic       seq_op;
  assign opc    = imem_data[15:12];
  assign seq_op = (opc != 4'd9) && (opc != 4'd10) && (opc != 4'd11);

  p_reset_fetch_r10: assert property (@(posedge clk)
    rst |-> imem_addr == '0);

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_no_access_r9: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!dmem_we && !dmem_re));

  p_halt_fetch_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(imem_addr));

  p_end_raises_halt_r9: assert property (@(posedge clk) disable iff (rst)
    (!halted && opc == 4'd11) |=> halted);

  p_seq_fetch_r12: assert property (@(posedge clk) disable iff (rst)
    (!halted && seq_op) |-> imem_addr == W'($past(imem_addr) + W'(1)));
endmodule

bind tcpu_core tcpu_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .dmem_re(dmem_re), .halted(halted)
);

// File: tb/tb_tcpu_core.sv
`timescale 1ns/1ps
module tb_tcpu_core;
  localparam int W = 8;
  localparam int DEPTH = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [15:0]  imem_data;
  logic         dmem_we, dmem_re, halted;

  logic [15:0]  prog [DEPTH];
  logic [W-1:0] dmem [DEPTH];
  int wp = 0;
  int checks = 0;
  int failures = 0;
  int bad_acc = 0;

  always #5 clk = ~clk;

  tcpu_core #(.W(W), .NUM_GPR(4)) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    imem_data <= prog[imem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    if (dmem_re) dmem_rdata <= dmem[dmem_addr];
  end

  always @(negedge clk)
    if (!rst && halted && (dmem_we || dmem_re)) bad_acc++;

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [15:0] ins(input int op, input int rd, input int ra, input int rb);
    return {op[3:0], rd[3:0], ra[3:0], rb[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    prog[wp] = w;
    wp++;
  endtask

  task automatic clear_all();
    for (int i = 0; i < DEPTH; i++) begin
      prog[i] = ins(11, 0, 0, 0);
      dmem[i] = 8'hA5;
    end
    wp = 0;
    bad_acc = 0;
  endtask

  task automatic boot_run(output int cyc);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted, "R9 run reaches halt", int'(halted), 1);
  endtask

  task automatic t_reset();
    clear_all();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(imem_addr == 0, "R10 fetch address in reset", int'(imem_addr), 0);
    chk(halted == 1'b0, "R10 halted low in reset", int'(halted), 0);
    chk(dmem_we == 1'b0, "R10 no write in reset", int'(dmem_we), 0);
  endtask

  task automatic t_arith();
    int cyc;
    clear_all();
    put(ins(8, 4, 0, 0));
    put(ins(8, 7, 8, 12));
    put(ins(8, 8, 4, 6));
    put(ins(1, 9, 7, 8));  put(ins(6, 0, 9, 0));
    put(ins(1, 4, 4, 1));
    put(ins(2, 9, 8, 7));  put(ins(6, 0, 9, 0));
    put(ins(1, 4, 4, 1));
    put(ins(3, 9, 7, 8));  put(ins(6, 0, 9, 0));
    put(ins(1, 4, 4, 1));
    put(ins(4, 9, 7, 0));  put(ins(6, 0, 9, 0));
    put(ins(1, 4, 4, 1));
    put(ins(8, 7, 15, 15));
    put(ins(4, 9, 7, 0));  put(ins(6, 0, 9, 0));
    put(ins(1, 4, 4, 1));
    put(ins(2, 9, 0, 1));  put(ins(6, 0, 9, 0));
    put(ins(11, 0, 0, 0));
    boot_run(cyc);
    chk(dmem[0] == 8'(200 + 100), "R1 add wraps", int'(dmem[0]), 44);
    chk(dmem[1] == 8'(100 - 200), "R1 sub wraps", int'(dmem[1]), 156);
    chk(dmem[2] == 8'(200 * 100), "R2 mul low bits", int'(dmem[2]), 32);
    chk(dmem[3] == 8'd100, "R2 halve", int'(dmem[3]), 100);
    chk(dmem[4] == 8'd127, "R2 halve is logical", int'(dmem[4]), 127);
    chk(dmem[5] == 8'd255, "R1 zero minus one", int'(dmem[5]), 255);
    chk(cyc == wp, "R12 one cycle per instruction", cyc, wp);
  endtask

  task automatic t_srcmap();
    int cyc;
    int pc_mark;
    clear_all();
    put(ins(8, 4, 10, 0));
    put(ins(8, 7, 10, 5));
    put(ins(6, 0, 7, 0));
    put(ins(1, 4, 4, 1));
    put(ins(8, 1, 9, 0));
    put(ins(6, 0, 1, 0));
    put(ins(1, 4, 4, 1));
    put(ins(6, 0, 3, 7));
    put(ins(1, 4, 4, 1));
    pc_mark = wp;
    put(ins(7, 8, 6, 0));
    put(ins(6, 0, 8, 0));
    put(ins(1, 4, 4, 1));
    put(ins(6, 0, 4, 0));
    put(ins(8, 12, 3, 3));
    put(ins(1, 4, 4, 1));
    put(ins(6, 0, 12, 0));
    put(ins(8, 5, 2, 4));
    put(ins(1, 4, 4, 1));
    put(ins(6, 0, 5, 0));
    put(ins(8, 0, 1, 1));
    put(ins(1, 4, 4, 1));
    put(ins(6, 0, 0, 0));
    put(ins(11, 0, 0, 0));
    boot_run(cyc);
    chk(dmem[10] == 8'h5A, "R3 immediate nibble order", int'(dmem[10]), 'h5A);
    chk(dmem[11] == 8'd1, "R4 constant one not writable", int'(dmem[11]), 1);
    chk(dmem[12] == 8'h73, "R4 immediate operand code 3", int'(dmem[12]), 'h73);
    chk(dmem[13] == 8'(pc_mark + 1), "R4 successor address operand", int'(dmem[13]), pc_mark + 1);
    chk(dmem[14] == 8'd14, "R4 address register operand", int'(dmem[14]), 14);
    chk(dmem[15] == 8'd0, "R4 unused code reads zero", int'(dmem[15]), 0);
    chk(dmem[16] == 8'h42, "R4 jump register operand", int'(dmem[16]), 'h42);
    chk(dmem[17] == 8'd0, "R4 constant zero not writable", int'(dmem[17]), 0);
  endtask

  task automatic t_load();
    int cyc;
    clear_all();
    dmem[20] = 8'h77;
    put(ins(8, 4, 4, 1));
    put(ins(5, 0, 0, 0));
    put(ins(7, 7, 2, 0));
    put(ins(8, 4, 5, 1));
    put(ins(6, 0, 7, 0));
    put(ins(8, 4, 6, 1));
    put(ins(6, 0, 2, 0));
    put(ins(8, 8, 12, 3));
    put(ins(8, 4, 8, 1));
    put(ins(6, 0, 8, 0));
    put(ins(5, 0, 0, 0));
    put(ins(7, 9, 2, 0));
    put(ins(8, 4, 9, 1));
    put(ins(6, 0, 9, 0));
    put(ins(11, 0, 0, 0));
    boot_run(cyc);
    chk(dmem[21] == 8'h77, "R6 load then use", int'(dmem[21]), 'h77);
    chk(dmem[22] == 8'h77, "R6 read value holds", int'(dmem[22]), 'h77);
    chk(dmem[24] == 8'h3C, "R5 store lands", int'(dmem[24]), 'h3C);
    chk(dmem[25] == 8'h3C, "R6 load after store", int'(dmem[25]), 'h3C);
    chk(dmem[23] == 8'hA5, "R5 no stray store", int'(dmem[23]), 'hA5);
  endtask

  task automatic t_branch();
    int cyc;
    clear_all();
    put(ins(8, 4, 14, 1));
    put(ins(8, 7, 8, 12));
    put(ins(8, 8, 4, 6));
    put(ins(8, 5, 6, 0));
    put(ins(10, 0, 7, 8));
    put(ins(6, 0, 1, 0));
    put(ins(8, 4, 15, 1));
    put(ins(8, 5, 10, 0));
    put(ins(9, 0, 7, 7));
    put(ins(6, 0, 1, 0));
    put(ins(8, 4, 0, 2));
    put(ins(8, 5, 14, 0));
    put(ins(9, 0, 7, 8));
    put(ins(6, 0, 1, 0));
    put(ins(8, 4, 1, 2));
    put(ins(8, 5, 2, 1));
    put(ins(10, 0, 8, 7));
    put(ins(6, 0, 1, 0));
    put(ins(11, 0, 0, 0));
    boot_run(cyc);
    chk(dmem[30] == 8'd1, "R8 unsigned less-than not taken", int'(dmem[30]), 1);
    chk(dmem[31] == 8'hA5, "R7 equal branch taken", int'(dmem[31]), 'hA5);
    chk(dmem[32] == 8'd1, "R7 unequal falls through", int'(dmem[32]), 1);
    chk(dmem[33] == 8'hA5, "R8 less-than taken", int'(dmem[33]), 'hA5);
    chk(cyc == 17, "R7 cycle count with two skips", cyc, 17);
  endtask

  task automatic t_loop();
    int cyc;
    clear_all();
    put(ins(8, 4, 0, 0));
    put(ins(8, 7, 10, 0));
    put(ins(8, 5, 3, 0));
    put(ins(1, 8, 4, 1));
    put(ins(3, 8, 4, 8));
    put(ins(4, 8, 8, 0));
    put(ins(6, 0, 8, 0));
    put(ins(1, 4, 4, 1));
    put(ins(10, 0, 4, 7));
    put(ins(11, 0, 0, 0));
    boot_run(cyc);
    for (int n = 0; n < 10; n++)
      chk(dmem[n] == 8'(n * (n + 1) / 2), "R8 loop result", int'(dmem[n]), n * (n + 1) / 2);
    chk(cyc == 64, "R12 loop cycle count", cyc, 64);
  endtask

  task automatic t_halt_nop();
    int cyc;
    logic [W-1:0] hold;
    clear_all();
    put(ins(8, 4, 2, 3));
    put(ins(8, 7, 1, 2));
    put(ins(12, 7, 1, 1));
    put(ins(13, 4, 1, 0));
    put(ins(14, 5, 3, 3));
    put(ins(15, 7, 0, 0));
    put(ins(0, 7, 1, 1));
    put(ins(6, 0, 7, 0));
    put(ins(11, 0, 0, 0));
    put(ins(8, 4, 3, 3));
    put(ins(6, 0, 1, 0));
    boot_run(cyc);
    chk(cyc == 9, "R12 halt after straight-line run", cyc, 9);
    chk(dmem[50] == 8'h21, "R11 no-op opcodes keep state", int'(dmem[50]), 'h21);
    hold = imem_addr;
    chk(hold == 8'd8, "R9 fetch holds at halt address", int'(hold), 8);
    repeat (10) @(negedge clk);
    chk(imem_addr == hold, "R9 fetch frozen", int'(imem_addr), int'(hold));
    chk(halted == 1'b1, "R9 halt sticky", int'(halted), 1);
    chk(dmem[51] == 8'hA5 && dmem[51 - 1] == 8'h21, "R9 nothing after halt", int'(dmem[51]), 'hA5);
    chk(bad_acc == 0, "R9 no access while halted", bad_acc, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(halted == 1'b0 && imem_addr == 0, "R10 reset clears halt", int'(halted), 0);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_srcmap();
    t_load();
    t_branch();
    t_loop();
    t_halt_nop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule